// File: doc/BRIEF.md
# Virtual-Channel Switch Allocator with Post-Grant Output VC Assignment

This block decides, every clock cycle, which flits of a virtual-channel router may cross the crossbar. The router has `NPORT` input ports with `NVC` input virtual channels each, and `NPORT` output ports with `NVC` output virtual channels each. Each input VC presents at most one request naming a target output port. A packet whose head has not yet been given an output VC requests speculatively. A flit that already holds an output VC requests non-speculatively. Matching is separable: a round-robin arbiter at each input picks one eligible VC, then a round-robin arbiter at each output picks one input. Non-speculative candidates are served before speculative ones.

A speculative winner takes an output VC only after it has won the output. It gets the lowest-numbered output VC that is free and holds a credit. If none exists, the grant is dropped and that output's slot goes unused for the cycle. Each output VC has its own credit counter. An output VC goes back to the free list only after the tail flit that owned it has left and a release pulse for it arrives afterwards. Grants are combinational in the same cycle as the requests. All bookkeeping is registered at the clock edge.

Top module: `vcsa_top`

## Requirements
- R1: A grant (`gnt` bit) is raised only for an input VC whose `req_valid` is high in that cycle and which is eligible. With no requests, and directly after reset, `gnt` is all zero. Input VC index i = port*NVC + vc.
- R2: At most one input VC of any input port is granted in a cycle.
- R3: At most one input VC is granted per output port in a cycle. The output port of input VC i is `req_port[i*PW +: PW]`.
- R4: A non-speculative grant reports on `gnt_ovc[i*VW +: VW]` the output VC that input VC received at its most recent speculative grant.
- R5: A speculative winner is given the lowest-numbered output VC of its target port that is free and has a nonzero credit count.
- R6: At an output port, an eligible non-speculative candidate wins over every speculative candidate, whatever the round-robin pointer prefers.
- R7: If a speculative winner finds no free output VC with credit, nothing is granted at that output in that cycle. Neither that output's pointer nor the input's pointer moves.
- R8: Both arbitration stages are round-robin. After a grant is used, the input pointer moves to one past the granted VC and the output pointer moves to one past the granted input. Unused choices leave the pointers unchanged.
- R9: Credit counters reset to `DEPTH` and drop by one for each flit sent on that output VC. A non-speculative request whose held output VC has zero credits is not eligible.
- R10: A `cred_ret` pulse on output VC k = port*NVC + vc adds one credit, visible from the next cycle.
- R11: An output VC rejoins the free list only when `vc_release` for it is seen in a cycle after its tail flit was sent. A release while the VC is unallocated, still carrying its packet, or in the same cycle as the tail is ignored.
- R12: A request is ignored if its speculative bit disagrees with its holding state. This covers a speculative request from an input VC that holds an output VC, and a non-speculative request from one that does not. A granted tail flit ends the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT*NVC | Request present, one bit per input VC |
| req_port | input | NPORT*NVC*PW | Target output port per input VC |
| req_spec | input | NPORT*NVC | 1: head flit without an output VC; 0: flit of a packet that holds one |
| req_tail | input | NPORT*NVC | Requesting flit is the last of its packet |
| gnt | output | NPORT*NVC | Grant per input VC, same cycle |
| gnt_ovc | output | NPORT*NVC*VW | Output VC used by each granted flit |
| cred_ret | input | NPORT*NVC | One credit returned per output VC |
| vc_release | input | NPORT*NVC | Downstream release per output VC |

## Verification
The bench goes after these corner cases:
- a release pulse that arrives while a packet still owns its VC; a design that honoured it would later hand that VC to a second packet;
- a speculative head meeting a port whose VCs are all draining; a design that granted anyway would double-book a VC or move the arbitration pointers on a discarded slot;
- the credit stall, where the last credit is spent and one returns; an off-by-one here would send a flit into a full buffer or stall one cycle too long;
- a non-speculative flit competing with a speculative one that the round-robin pointer favours, which exposes a missing priority stage;
- requests whose speculative bit contradicts the holding state, which must not be granted;
- long random traffic, compared every cycle against a behavioural model, which exposes pointers that advance on unused grants.

// File: rtl/vcsa_pkg.sv
package vcsa_pkg;
    typedef enum logic [1:0] {
        OVC_FREE  = 2'd0,
        OVC_BUSY  = 2'd1,
        OVC_DRAIN = 2'd2
    } ovc_state_e;
endpackage

// File: rtl/vcsa_rr.sv
// Round-robin picker: first set request at or after ptr, wrapping.
module vcsa_rr #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (!any && req[IW'((int'(ptr) + k) % W)]) begin
                any = 1'b1;
                idx = IW'((int'(ptr) + k) % W);
            end
        end
    end
endmodule

// File: rtl/vcsa_ovc.sv
// Per-output-port tracker: output VC ownership state and credit counters.
module vcsa_ovc
    import vcsa_pkg::*;
#(
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    localparam int VW = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc,
    input  logic           send,
    input  logic [VW-1:0]  held_vc,
    input  logic           tail,
    input  logic [NVC-1:0] rel,
    input  logic [NVC-1:0] cret,
    output logic           avail_any,
    output logic [VW-1:0]  first_vc,
    output logic [NVC-1:0] cred_ok
);
    typedef struct packed {
        ovc_state_e [NVC-1:0]          st;
        logic       [NVC-1:0][CW-1:0]  cred;
    } trk_t;

    trk_t q, d;
    logic [NVC-1:0] avail;
    logic [VW-1:0]  use_vc;

    // Outputs depend on registered state only.
    always_comb begin
        first_vc = '0;
        for (int v = 0; v < NVC; v++) begin
            cred_ok[v] = (q.cred[v] != '0);
            avail[v]   = (q.st[v] == OVC_FREE) && cred_ok[v];
        end
        for (int v = NVC - 1; v >= 0; v--) begin
            if (avail[v]) first_vc = VW'(v);
        end
        avail_any = |avail;
    end

    always_comb begin
        d      = q;
        use_vc = alloc ? first_vc : held_vc;
        for (int v = 0; v < NVC; v++) begin
            if (rel[v] && q.st[v] == OVC_DRAIN) d.st[v] = OVC_FREE;
        end
        if (send) begin
            if (alloc)     d.st[use_vc] = tail ? OVC_DRAIN : OVC_BUSY;
            else if (tail) d.st[use_vc] = OVC_DRAIN;
        end
        for (int v = 0; v < NVC; v++) begin
            case ({cret[v], send && (use_vc == VW'(v))})
                2'b10:   d.cred[v] = q.cred[v] + CW'(1);
                2'b01:   d.cred[v] = q.cred[v] - CW'(1);
                default: d.cred[v] = q.cred[v];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NVC; v++) begin
                q.st[v]   <= OVC_FREE;
                q.cred[v] <= CW'(DEPTH);
            end
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vcsa_top.sv
module vcsa_top #(
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    parameter int DEPTH = 4,
    localparam int NIV = NPORT * NVC,
    localparam int PW  = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW  = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int IVW = (NIV > 1) ? $clog2(NIV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIV-1:0]    req_valid,
    input  logic [NIV*PW-1:0] req_port,
    input  logic [NIV-1:0]    req_spec,
    input  logic [NIV-1:0]    req_tail,
    output logic [NIV-1:0]    gnt,
    output logic [NIV*VW-1:0] gnt_ovc,
    input  logic [NIV-1:0]    cred_ret,
    input  logic [NIV-1:0]    vc_release
);
    typedef struct packed {
        logic [NIV-1:0]            held;
        logic [NIV-1:0][VW-1:0]    hovc;
        logic [NPORT-1:0][VW-1:0]  iptr;
        logic [NPORT-1:0][PW-1:0]  optr;
    } st_t;

    st_t q, d;

    logic [PW-1:0]             port_a [NIV];
    logic [NIV-1:0]            elig;
    logic [NPORT-1:0][VW-1:0]  in_idx;
    logic [NPORT-1:0]          in_any;
    logic [NPORT-1:0][PW-1:0]  w_port;
    logic [NPORT-1:0]          w_spec;
    logic [NPORT-1:0][NPORT-1:0] ns_req, sp_req;
    logic [NPORT-1:0][PW-1:0]  ns_idx, sp_idx;
    logic [NPORT-1:0]          ns_any, sp_any;
    logic [NPORT-1:0][PW-1:0]  o_inp;
    logic [NPORT-1:0]          o_spec, o_used;
    logic [NPORT-1:0][IVW-1:0] o_ivc;
    logic [NPORT-1:0][VW-1:0]  trk_hvc;
    logic [NPORT-1:0]          trk_tail;
    logic [NPORT-1:0]          tk_avail;
    logic [NPORT-1:0][VW-1:0]  tk_first;
    logic [NPORT-1:0][NVC-1:0] tk_cred_ok;

    for (genvar i = 0; i < NIV; i++) begin : g_port
        assign port_a[i] = req_port[i*PW +: PW];
    end

    // Eligibility: spec bit must match holding state; held VC needs a credit.
    always_comb begin
        for (int i = 0; i < NIV; i++) begin
            elig[i] = 1'b0;
            if (req_valid[i] && int'(port_a[i]) < NPORT) begin
                if (req_spec[i]) elig[i] = !q.held[i];
                else             elig[i] = q.held[i] && tk_cred_ok[port_a[i]][q.hovc[i]];
            end
        end
    end

    // Stage 1: one VC per input port.
    for (genvar p = 0; p < NPORT; p++) begin : g_in
        vcsa_rr #(.W(NVC)) u_in_rr (
            .req (elig[p*NVC +: NVC]),
            .ptr (q.iptr[p]),
            .idx (in_idx[p]),
            .any (in_any[p])
        );
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            w_port[p] = port_a[p*NVC + int'(in_idx[p])];
            w_spec[p] = req_spec[p*NVC + int'(in_idx[p])];
        end
        for (int o = 0; o < NPORT; o++) begin
            for (int p = 0; p < NPORT; p++) begin
                ns_req[o][p] = in_any[p] && (int'(w_port[p]) == o) && !w_spec[p];
                sp_req[o][p] = in_any[p] && (int'(w_port[p]) == o) &&  w_spec[p];
            end
        end
    end

    // Stage 2: one input per output, non-speculative class first.
    for (genvar o = 0; o < NPORT; o++) begin : g_out
        vcsa_rr #(.W(NPORT)) u_ns_rr (
            .req (ns_req[o]),
            .ptr (q.optr[o]),
            .idx (ns_idx[o]),
            .any (ns_any[o])
        );
        vcsa_rr #(.W(NPORT)) u_sp_rr (
            .req (sp_req[o]),
            .ptr (q.optr[o]),
            .idx (sp_idx[o]),
            .any (sp_any[o])
        );
        vcsa_ovc #(.NVC(NVC), .DEPTH(DEPTH)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (o_used[o] && o_spec[o]),
            .send      (o_used[o]),
            .held_vc   (trk_hvc[o]),
            .tail      (trk_tail[o]),
            .rel       (vc_release[o*NVC +: NVC]),
            .cret      (cred_ret[o*NVC +: NVC]),
            .avail_any (tk_avail[o]),
            .first_vc  (tk_first[o]),
            .cred_ok   (tk_cred_ok[o])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            o_spec[o]   = !ns_any[o];
            o_inp[o]    = ns_any[o] ? ns_idx[o] : sp_idx[o];
            o_used[o]   = ns_any[o] || (sp_any[o] && tk_avail[o]);
            o_ivc[o]    = IVW'(int'(o_inp[o]) * NVC + int'(in_idx[o_inp[o]]));
            trk_hvc[o]  = q.hovc[o_ivc[o]];
            trk_tail[o] = req_tail[o_ivc[o]];
        end
    end

    // Grants and next state.
    always_comb begin
        d       = q;
        gnt     = '0;
        gnt_ovc = '0;
        for (int o = 0; o < NPORT; o++) begin
            if (o_used[o]) begin
                gnt[o_ivc[o]] = 1'b1;
                if (o_spec[o]) begin
                    gnt_ovc[int'(o_ivc[o])*VW +: VW] = tk_first[o];
                    d.held[o_ivc[o]] = !req_tail[o_ivc[o]];
                    d.hovc[o_ivc[o]] = tk_first[o];
                end else begin
                    gnt_ovc[int'(o_ivc[o])*VW +: VW] = q.hovc[o_ivc[o]];
                    if (req_tail[o_ivc[o]]) d.held[o_ivc[o]] = 1'b0;
                end
                d.iptr[o_inp[o]] = (int'(in_idx[o_inp[o]]) == NVC - 1) ? '0
                                 : in_idx[o_inp[o]] + VW'(1);
                d.optr[o] = (int'(o_inp[o]) == NPORT - 1) ? '0 : o_inp[o] + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/vcsa_chk.sv
module vcsa_chk #(
    parameter int NPORT = 4,
    parameter int NVC   = 2,
    localparam int NIV = NPORT * NVC,
    localparam int PW  = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int VW  = (NVC > 1) ? $clog2(NVC) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NIV-1:0]    req_valid,
    input logic [NIV-1:0]    req_spec,
    input logic [NIV*PW-1:0] req_port,
    input logic [NIV-1:0]    gnt,
    input logic [NIV*VW-1:0] gnt_ovc
);
    int out_cnt [NPORT];
    logic [VW-1:0] last_ovc [NIV];

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            out_cnt[o] = 0;
            for (int i = 0; i < NIV; i++) begin
                if (gnt[i] && int'(req_port[i*PW +: PW]) == o) out_cnt[o]++;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NIV; i++) last_ovc[i] <= '0;
        end else begin
            for (int i = 0; i < NIV; i++) begin
                if (gnt[i] && req_spec[i]) last_ovc[i] <= gnt_ovc[i*VW +: VW];
            end
        end
    end

    // R1
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_valid) == '0);

    for (genvar p = 0; p < NPORT; p++) begin : g_in_chk
        // R2
        one_per_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gnt[p*NVC +: NVC]) <= 1);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out_chk
        // R3
        one_per_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_cnt[o] <= 1);
    end

    for (genvar i = 0; i < NIV; i++) begin : g_ovc_chk
        // R4
        held_ovc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && !req_spec[i]) |-> (gnt_ovc[i*VW +: VW] == last_ovc[i]));
    end
endmodule

bind vcsa_top vcsa_chk #(.NPORT(NPORT), .NVC(NVC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_spec  (req_spec),
    .req_port  (req_port),
    .gnt       (gnt),
    .gnt_ovc   (gnt_ovc)
);

// File: tb/vcsa_top_tb_top.sv
module vcsa_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3, V = 2, DEPTH = 2;
    localparam int NIV = N * V, PW = 2, VW = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NIV-1:0]    rv = '0, rs = '0, rt = '0, cr = '0, rl = '0;
    logic [NIV*PW-1:0] rp = '0;
    logic [NIV-1:0]    gnt;
    logic [NIV*VW-1:0] gnt_ovc;

    int errors = 0, checks = 0;
    bit done = 0;

    // behavioural reference state
    int held [NIV], hovc [NIV], inptr [N], outptr [N];
    int ost [NIV], cred [NIV];   // ost: 0 free, 1 carrying, 2 tail gone
    int win [N], osel [N], ospec [N], oovc [N];
    int eg [NIV], eo [NIV];

    always #(CLK_PERIOD/2) clk = ~clk;

    vcsa_top #(.NPORT(N), .NVC(V), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_port(rp),
        .req_spec(rs), .req_tail(rt), .gnt(gnt), .gnt_ovc(gnt_ovc),
        .cred_ret(cr), .vc_release(rl));

    function automatic int pt(int i);
        return int'(rp[i*PW +: PW]);
    endfunction

    function automatic int first_av(int o);
        for (int v = 0; v < V; v++)
            if (ost[o*V+v] == 0 && cred[o*V+v] > 0) return v;
        return -1;
    endfunction

    function automatic bit elig(int i);
        if (!rv[i] || pt(i) >= N) return 0;
        if (rs[i]) return held[i] == 0;
        return held[i] != 0 && cred[pt(i)*V + hovc[i]] > 0;
    endfunction

    task automatic model_eval();
        for (int i = 0; i < NIV; i++) begin eg[i] = 0; eo[i] = 0; end
        for (int p = 0; p < N; p++) begin
            win[p] = -1;
            for (int k = 0; k < V; k++) begin
                int v = (inptr[p] + k) % V;
                if (win[p] < 0 && elig(p*V+v)) win[p] = v;
            end
        end
        for (int o = 0; o < N; o++) begin
            osel[o] = -1; ospec[o] = 0;
            for (int pass = 0; pass < 2; pass++) begin
                for (int k = 0; k < N; k++) begin
                    int p = (outptr[o] + k) % N;
                    if (osel[o] < 0 && pass == ospec[o] && win[p] >= 0
                        && pt(p*V+win[p]) == o && rs[p*V+win[p]] == (pass == 1))
                        osel[o] = p;
                end
                if (osel[o] < 0 && pass == 0) ospec[o] = 1;
            end
            if (osel[o] >= 0) begin
                int i = osel[o]*V + win[osel[o]];
                oovc[o] = ospec[o] ? first_av(o) : hovc[i];
                if (oovc[o] < 0) osel[o] = -1;
                else begin eg[i] = 1; eo[i] = oovc[o]; end
            end
        end
    endtask

    task automatic model_commit();
        for (int k = 0; k < NIV; k++) if (rl[k] && ost[k] == 2) ost[k] = 0;
        for (int o = 0; o < N; o++) begin
            if (osel[o] >= 0) begin
                int p = osel[o];
                int i = p*V + win[p];
                int k = o*V + oovc[o];
                cred[k]--;
                if (ospec[o]) begin
                    ost[k] = rt[i] ? 2 : 1;
                    held[i] = rt[i] ? 0 : 1;
                    hovc[i] = oovc[o];
                end else if (rt[i]) begin
                    ost[k] = 2; held[i] = 0;
                end
                inptr[p] = (win[p] + 1) % V;
                outptr[o] = (p + 1) % N;
            end
        end
        for (int k = 0; k < NIV; k++) if (cr[k]) cred[k]++;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sample at negedge: compare against model, then advance it
    task automatic tick(string tag);
        @(negedge clk);
        model_eval();
        checks++;
        for (int i = 0; i < NIV; i++) begin
            if (gnt[i] != eg[i] || (eg[i] != 0 && int'(gnt_ovc[i*VW +: VW]) != eo[i])) begin
                errors++;
                $display("FAIL %s: ivc %0d actual gnt=%0d ovc=%0d expected gnt=%0d ovc=%0d",
                         tag, i, gnt[i], gnt_ovc[i*VW +: VW], eg[i], eo[i]);
                break;
            end
        end
        model_commit();
        @(posedge clk); #1;
        cr = '0; rl = '0;
    endtask

    task automatic look(string tag, int i, int g, int ov);
        #1;
        check(tag, gnt[i], g);
        if (g != 0) check(tag, int'(gnt_ovc[i*VW +: VW]), ov);
    endtask

    task automatic setreq(int i, int port, bit spec, bit tail);
        rv[i] = 1; rp[i*PW +: PW] = PW'(port); rs[i] = spec; rt[i] = tail;
    endtask

    task automatic clr();
        rv = '0; rs = '0; rt = '0;
    endtask

    initial begin
        for (int i = 0; i < NIV; i++) begin
            held[i] = 0; hovc[i] = 0; ost[i] = 0; cred[i] = DEPTH;
        end
        for (int p = 0; p < N; p++) begin inptr[p] = 0; outptr[p] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset
        look("R1", 0, 0, 0); check("R1", int'(gnt), 0); tick("R1");

        // R5: first speculative head on out1 gets VC 0
        setreq(0, 1, 1, 0); look("R5", 0, 1, 0); tick("R5");
        // R4 + R11: body reuses VC 0; early release while carrying is ignored
        setreq(0, 1, 0, 0); rl[2] = 1; look("R4", 0, 1, 0); tick("R4");
        // R9: credits exhausted (DEPTH=2)
        look("R9", 0, 0, 0); tick("R9");
        cr[2] = 1; look("R9", 0, 0, 0); tick("R10");
        // R10: returned credit lets the tail go
        setreq(0, 1, 0, 1); look("R10", 0, 1, 0); tick("R10");

        // R11: VC 0 drained but not released -> next head gets VC 1
        clr(); setreq(2, 1, 1, 1); cr[2] = 1; look("R11", 2, 1, 1); tick("R11");
        // R7: both VCs of out1 draining -> no grant
        clr(); setreq(4, 1, 1, 0); look("R7", 4, 0, 0); tick("R7");
        rl[2] = 1; look("R7", 4, 0, 0); tick("R11");
        look("R11", 4, 1, 0); tick("R11");

        // R6: held flit beats a speculative head favoured by the pointer
        clr(); setreq(1, 2, 1, 0); look("R5", 1, 1, 0); tick("R5");
        setreq(1, 2, 0, 0); setreq(2, 2, 1, 0);
        look("R6", 1, 1, 0); look("R6", 2, 0, 0); tick("R6");
        // R9: held VC out of credit -> speculative head proceeds on VC 1
        look("R9", 1, 0, 0); look("R9", 2, 1, 1); tick("R9");

        // R12: mismatched speculative bits are ignored
        clr(); setreq(3, 0, 0, 0); setreq(2, 0, 1, 0);
        look("R12", 3, 0, 0); look("R12", 2, 0, 0); tick("R12");

        // R2 R3 R8: random traffic against the model
        clr();
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NIV; i++) begin
                rv[i] = ($urandom % 2) != 0;
                rp[i*PW +: PW] = PW'($urandom % N);
                rs[i] = (held[i] != 0) ? (($urandom % 8) == 0) : (($urandom % 8) != 0);
                rt[i] = ($urandom % 4) == 0;
            end
            for (int k = 0; k < NIV; k++) begin
                cr[k] = (cred[k] < DEPTH) && (($urandom % 3) == 0);
                rl[k] = ($urandom % 5) == 0;
            end
            tick("R2 R3 R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule